// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block is a programmable interval timer that raises a periodic interrupt. A 16-bit down-counter is slowed by an 8-bit prescaler: the counter steps once every (scale + 1) enabled clock cycles. When a prescaler tick finds the counter at zero, the counter is refilled from a 16-bit period register and a one-cycle interrupt pulse is produced. With the counter reloaded to a period value P and a scale value S, the interrupt repeats every (P + 1) x (S + 1) enabled cycles.

Software sets up the timer through a small register port with separate write and read strobes and a 2-bit register select. The counter itself is writable, which lets software restart a countdown at any time. An enable input freezes the whole timer when low. Masking and prioritising the interrupt belong to the interrupt controller and are not part of this block.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter, period and scale registers read 0 and `irq` is low.
- R2: Register select encoding: 0 = counter, 1 = period, 2 = scale (stores `wr_data[7:0]`, reads back zero-extended). A write occurs on a clock edge with `wr_en` high; `rd_data` shows the selected register in the same cycle while `rd_en` is high and is 0 while `rd_en` is low.
- R3: With the timer enabled the counter decrements by one once every (scale + 1) enabled cycles; scale 0 decrements on every enabled cycle.
- R4: A prescaler tick that finds the counter at 0 reloads it from the period register; `irq` is high for exactly the cycle in which the counter first shows the reloaded value, so interrupts repeat every (period + 1) x (scale + 1) enabled cycles.
- R5: With a period of 0 an interrupt is produced on every prescaler tick; with scale 0 as well, `irq` stays high on every enabled cycle.
- R6: A counter write replaces the count, restarts the prescaler phase at zero and suppresses any reload or interrupt on that edge; it takes effect whether or not the timer is enabled.
- R7: While `en` is low the prescaler phase and the counter hold their values and no interrupt is produced.
- R8: A period write does not disturb a countdown in progress; the new period is used from the next reload.
- R9: If the scale is lowered below the current prescaler phase, the next enabled cycle produces a tick.
- R10: A write with select 3 changes no register and causes no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Timer enable; low freezes prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | One-cycle interrupt pulse at each reload |

## Verification
Any corruption of the prescaler phase or the counter surfaces as an interrupt on the wrong enabled cycle, so the bench predicts the exact enabled-cycle index of every pulse from the (P + 1) x (S + 1) formula and flags a pulse that is early, late, missing or extra within one cycle of the deviation. A fault that does not move an interrupt, such as a held state while disabled or a lost scale or period bit, is brought out through counter and register reads taken between edges, so it appears on `rd_data` in the cycle after the edge that caused it.

// File: rtl/tick_timer_pkg.sv
// Package tick_timer_pkg
// Shared definitions for the interval timer: the register select codes
// used by the write and read ports.
package tick_timer_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_NONE   = 2'd3
    } tmr_sel_e;

endpackage

// File: rtl/timer_regs.sv
// Module timer_regs
// Holds the period and scale registers, decodes counter writes into a
// load strobe for the counter, and drives the read mux.
// Assumes SCL_W <= CNT_W; writes with an unused select are dropped.
module timer_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    input  logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] period_q,
    output logic [SCL_W-1:0] scale_q,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic [CNT_W-1:0] rd_data
);
    localparam int PAD = CNT_W - SCL_W;

    logic [CNT_W-1:0] scale_ext;

    // Zero-extend the scale register to the read width.
    generate
        if (PAD > 0) begin : g_pad
            logic wr_hi_unused;
            assign scale_ext    = {{PAD{1'b0}}, scale_q};
            assign wr_hi_unused = ^wr_data[CNT_W-1:SCL_W];
        end else begin : g_nopad
            assign scale_ext = scale_q;
        end
    endgenerate

    // Period and scale storage, written by the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            scale_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PERIOD) period_q <= wr_data;
            if (wr_sel == SEL_SCALE)  scale_q  <= wr_data[SCL_W-1:0];
        end
    end

    // Counter writes pass straight to the down-counter as a load.
    assign cnt_load     = wr_en && (wr_sel == SEL_COUNT);
    assign cnt_load_val = wr_data;

    // Read mux; zero whenever no read is requested.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_sel)
                SEL_COUNT:  rd_data = count_val;
                SEL_PERIOD: rd_data = period_q;
                SEL_SCALE:  rd_data = scale_ext;
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/timer_prescaler.sv
// Module timer_prescaler
// Counts enabled cycles from 0 up to the scale value and emits a tick
// on the cycle the phase reaches (or has passed) the scale value.
// Assumes restart has priority; restart clears the phase even when off.
module timer_prescaler #(
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [SCL_W-1:0] scale,
    output logic [SCL_W-1:0] phase,
    output logic             tick
);
    // Tick when the phase has reached the limit, so a lowered scale
    // produces a tick at once instead of wrapping the phase.
    assign tick = en && !restart && (phase >= scale);

    // Phase counter: cleared on restart, advanced on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (en) begin
            phase <= tick ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/timer_downcount.sv
// Module timer_downcount
// The counter proper: loads from the register port, steps down on each
// prescaler tick, and at a tick with the count at zero reloads from the
// period and raises a one-cycle interrupt alongside the reloaded value.
module timer_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic at_zero;

    assign at_zero = (count == '0);

    // Count and interrupt register: load beats tick, tick at zero reloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else if (load) begin
            count <= load_val;
            irq   <= 1'b0;
        end else if (tick) begin
            count <= at_zero ? period : count - 1'b1;
            irq   <= at_zero;
        end else begin
            irq   <= 1'b0;
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Module tick_timer
// Top of the prescaled reloading interval timer: register port,
// prescaler and down-counter. Reset is synchronous and active low.
module tick_timer #(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    logic [CNT_W-1:0] period_q;
    logic [SCL_W-1:0] scale_q;
    logic [SCL_W-1:0] phase;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_load;
    logic             tick;

    timer_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .count_val    (count),
        .period_q     (period_q),
        .scale_q      (scale_q),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .rd_data      (rd_data)
    );

    timer_prescaler #(.SCL_W(SCL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .restart (cnt_load),
        .scale   (scale_q),
        .phase   (phase),
        .tick    (tick)
    );

    timer_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .period   (period_q),
        .count    (count),
        .irq      (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Module tick_timer_chk
// Property checker for tick_timer, attached by bind. Observes the ports
// and the counter, phase and period state of the timer.
module tick_timer_chk #(
    parameter int CNT_W = 16,
    parameter int SCL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period_q,
    input logic [SCL_W-1:0] phase
);
    logic cnt_wr;

    assign cnt_wr = wr_en && (wr_sel == 2'd0);

    // R4
    irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == $past(period_q)));

    // R6
    count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wr_data)) && (phase == '0) && !irq);

    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(count) && $stable(phase) && !irq);

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cnt_wr && count != '0) |=>
            (count == $past(count)) || (count == $past(count) - CNT_W'(1)));

    // R7
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .irq      (irq),
    .count    (count),
    .period_q (period_q),
    .phase    (phase)
);

// File: tb/tick_timer_bench.sv
// Scoreboard bench for tick_timer: the driver pushes the enabled-cycle
// index at which each interrupt is due; a monitor pops and compares.
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int en_cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    int    q_at[$];
    string q_req[$];

    tick_timer u_tick_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    // Enabled-edge counter: the time base of the scoreboard.
    always @(posedge clk) if (rst_n && en) en_cyc <= en_cyc + 1;

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] sel, output int val);
        rd_en = 1'b1; rd_sel = sel;
        #1 val = int'(rd_data);
        rd_en = 1'b0;
    endtask

    // Write the counter with en high; returns the enabled-cycle base.
    task automatic start_run(logic [15:0] c, output int base);
        @(negedge clk);
        en = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = c;
        @(negedge clk);
        wr_en = 1'b0;
        base = en_cyc;
    endtask

    // Driver side of the scoreboard: queue n expected interrupts.
    task automatic expect_irqs(string req, int first, int step, int n);
        for (int i = 0; i < n; i++) begin
            q_at.push_back(first + i * step);
            q_req.push_back(req);
        end
    endtask

    task automatic drain(string req, int n);
        repeat (n) @(negedge clk);
        chk(req, q_at.size(), 0);
    endtask

    // Monitor: compare each interrupt against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (mon_on) begin
                if (irq) begin
                    checks++;
                    if (q_at.size() == 0) begin
                        errors++;
                        $display("FAIL unexpected irq at enabled cycle %0d (expected none)", en_cyc);
                    end else begin
                        if (q_at[0] != en_cyc) begin
                            errors++;
                            $display("FAIL %s: irq at enabled cycle %0d expected %0d",
                                     q_req[0], en_cyc, q_at[0]);
                        end
                        void'(q_at.pop_front());
                        void'(q_req.pop_front());
                    end
                end else if (q_at.size() != 0 && q_at[0] <= en_cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL %s: irq missing at enabled cycle %0d expected high",
                             q_req[0], q_at[0]);
                    void'(q_at.pop_front());
                    void'(q_req.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end (got timeout, expected finish)");
        finish_sim();
    end

    initial begin
        int v, base, a, b;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, v); chk("R1 count after reset", v, 0);
        rd(2'd1, v); chk("R1 period after reset", v, 0);
        rd(2'd2, v); chk("R1 scale after reset", v, 0);
        chk("R1 irq after reset", int'(irq), 0);

        // R2: readback, scale truncated to 8 bits, rd_en low gives 0
        wr(2'd1, 16'h1234); wr(2'd2, 16'hABCD);
        rd(2'd1, v); chk("R2 period readback", v, 16'h1234);
        rd(2'd2, v); chk("R2 scale readback", v, 16'h00CD);
        rd_sel = 2'd1; #1 chk("R2 rd_en low reads 0", int'(rd_data), 0);

        // R10: select 3 write changes nothing
        wr(2'd3, 16'hFFFF);
        rd(2'd1, v); chk("R10 period kept", v, 16'h1234);
        rd(2'd2, v); chk("R10 scale kept", v, 16'h00CD);
        rd(2'd0, v); chk("R10 count kept", v, 0);
        chk("R10 no irq", int'(irq), 0);

        mon_on = 1'b1;
        // R4/R3: scale 0, period 3, count 2
        wr(2'd1, 16'd3); wr(2'd2, 16'd0);
        start_run(16'd2, base);
        expect_irqs("R4 s0 p3", base + 3, 4, 3);
        drain("R4 s0 p3 drained", 12);
        en = 1'b0;

        // R4/R3: scale 2, period 1, count 0 -> every 6
        wr(2'd1, 16'd1); wr(2'd2, 16'd2);
        start_run(16'd0, base);
        expect_irqs("R4 s2 p1", base + 3, 6, 3);
        drain("R4 s2 p1 drained", 16);
        en = 1'b0;

        // R5: scale 0, period 0 -> irq on every enabled cycle
        wr(2'd1, 16'd0); wr(2'd2, 16'd0);
        start_run(16'd0, base);
        expect_irqs("R5 period zero", base + 1, 1, 5);
        repeat (5) @(negedge clk);
        en = 1'b0;
        drain("R5 drained", 3);

        // R5: period 0 with scale 1 -> every 2
        wr(2'd2, 16'd1);
        start_run(16'd0, base);
        expect_irqs("R5 period zero s1", base + 2, 2, 3);
        repeat (6) @(negedge clk);
        en = 1'b0;
        drain("R5 s1 drained", 3);

        // R7: disable mid-run; schedule counted in enabled cycles
        wr(2'd1, 16'd4); wr(2'd2, 16'd1);
        start_run(16'd4, base);
        expect_irqs("R7 pause", base + 10, 10, 3);
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        rd(2'd0, a); chk("R7 count while off", a, 3);
        repeat (6) @(negedge clk);
        rd(2'd0, b); chk("R7 count held", b, a);
        en = 1'b1;
        drain("R7 drained", 34);
        en = 1'b0;

        // R8: period write mid-countdown takes effect at next reload
        wr(2'd1, 16'd2); wr(2'd2, 16'd0);
        start_run(16'd5, base);
        expect_irqs("R8 period change", base + 6, 7, 3);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd6;
        @(negedge clk);
        wr_en = 1'b0;
        drain("R8 drained", 24);
        en = 1'b0;

        // R6: counter overwrite restarts the prescaler phase
        wr(2'd1, 16'd3); wr(2'd2, 16'd2);
        start_run(16'd6, base);
        repeat (5) @(negedge clk);
        q_at.delete(); q_req.delete();
        start_run(16'd1, base);
        expect_irqs("R6 overwrite", base + 6, 12, 2);
        drain("R6 drained", 22);
        en = 1'b0;
        wr(2'd0, 16'd77);
        rd(2'd0, v); chk("R6 write while off", v, 77);

        // R9/R3: lowering scale below the phase ticks at once
        mon_on = 1'b0;
        wr(2'd2, 16'd200);
        start_run(16'd5, base);
        repeat (50) @(negedge clk);
        rd(2'd0, v); chk("R3 slow scale holds count", v, 5);
        wr(2'd2, 16'd3);
        rd(2'd0, v); chk("R9 before tick", v, 5);
        @(negedge clk);
        rd(2'd0, v); chk("R9 immediate tick", v, 4);
        repeat (4) @(negedge clk);
        rd(2'd0, v); chk("R3 tick every scale+1", v, 3);
        en = 1'b0;

        repeat (3) @(negedge clk);
        finish_sim();
    end

endmodule